// File: doc/BRIEF.md
# Set-Way Cache Maintenance Controller

This block looks after the directory of a four-way set-associative cache. It holds a small control register with three fields: a global enable, a policy bit that decides whether a pushed line is dropped afterwards, and a self-clearing command bit that invalidates the whole cache. It also carries out per-line push commands. A push names one directory entry by set and way. If that line is valid and modified, the block writes it back to memory over a valid/ready write channel. It then either invalidates the line or leaves it valid and clean, as the policy bit says.

The tag, state and data arrays live inside the block. A test-load port fills them and a probe port reads them back. Lookup hits and line fills are handled elsewhere. None of the maintenance commands look at the enable bit. Reset clears only the control register and the command engine, never the arrays.

The engine is a four-state machine:
- `ST_IDLE` goes to `ST_LOOK` when a push is pending. Otherwise it goes to `ST_SWEEP` when an invalidate-all is pending.
- `ST_LOOK` reads the addressed entry. It goes to `ST_BEAT` for a valid dirty line, and otherwise applies the policy and returns to `ST_IDLE`.
- `ST_BEAT` sends one word per accepted handshake. It returns to `ST_IDLE` after the last word, applying the policy then.
- `ST_SWEEP` clears one set per cycle and returns to `ST_IDLE` after the last set.

Top module: `cmc_top`

## Requirements
- R1: After reset, `cache_enable`, `push_inval_mode`, `busy` and `mw_valid` are all 0.
- R2: Reset leaves the valid, dirty, tag and data contents of every directory entry unchanged.
- R3: A control write sets the field values one cycle later: `cache_enable` from `ctl_wdata[0]` and `push_inval_mode` from `ctl_wdata[1]`. The enable value changes no directory content and does not alter how any maintenance command behaves.
- R4: A control write with `ctl_wdata[2]` set clears valid and dirty in every way of every set. It sweeps one set per cycle, so `busy` stays high for exactly SETS+1 cycles after the write edge (513 by default).
- R5: A push operand selects the set from bits 12:4 and the way from bits 1:0. Bits 31:13 and 3:2 are ignored.
- R6: A push of an invalid or clean line makes no memory write and keeps `busy` high for exactly 2 cycles. With the policy bit at 1 the line ends invalid; with it at 0 a valid line stays valid and clean.
- R7: A push of a valid dirty line sends four beats. Beat w has address {tag, set, w[1:0], 2'b00} and data equal to bits 32w+31:32w of the stored line, in ascending w. Address and data hold steady while `mw_ready` is low.
- R8: After a dirty push, the line ends invalid if the policy bit was 1, or valid and clean if it was 0. Without back-pressure, `busy` is high for exactly 6 cycles, falling on the cycle after the last beat is accepted.
- R9: `busy` rises the cycle after any command write. A command written while `busy` is high is held and carried out once the current one completes.
- R10: If a push and an invalidate-all are written in the same cycle, the push runs first, including its writeback, and the sweep follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control data: bit0 enable, bit1 push policy, bit2 invalidate-all |
| push_we | input | 1 | Push command strobe |
| push_op | input | 32 | Push operand: set in 12:4, way in 1:0 |
| busy | output | 1 | A command is pending or running |
| cache_enable | output | 1 | Enable field of the control register |
| push_inval_mode | output | 1 | Policy field: 1 drops the line after a push |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory write beat accepted |
| mw_addr | output | 32 | Byte address of the beat |
| mw_data | output | 32 | Beat data |
| tl_we | input | 1 | Test-load write strobe |
| tl_set | input | 9 | Test-load set |
| tl_way | input | 2 | Test-load way |
| tl_valid | input | 1 | Test-load valid state |
| tl_dirty | input | 1 | Test-load modified state |
| tl_tag | input | 19 | Test-load tag |
| tl_data | input | 128 | Test-load line data, word 0 in bits 31:0 |
| pr_set | input | 9 | Probe set |
| pr_way | input | 2 | Probe way |
| pr_valid | output | 1 | Probed valid state |
| pr_dirty | output | 1 | Probed modified state |
| pr_tag | output | 19 | Probed tag |
| pr_data | output | 128 | Probed line data |

## Verification
The checks assume three things about the inputs:
- Test loads happen only while `busy` is low.
- At most one push is held at a time.
- `mw_ready` may stall for any number of cycles.

The bench loads lines only between commands. It writes a second push only while a first one is running, never while another is already held. It toggles `mw_ready` on back-pressured vectors so that the stall path is exercised without starving the channel. Under these conditions the stability and beat-order properties on the write channel hold at every handshake.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    localparam int CM_SETS   = 512;
    localparam int CM_WAYS   = 4;
    localparam int CM_WORDS  = 4;
    localparam int CM_AW     = 32;
    localparam int CM_DW     = 32;
    localparam int CM_SET_W  = $clog2(CM_SETS);
    localparam int CM_WAY_W  = $clog2(CM_WAYS);
    localparam int CM_BEAT_W = $clog2(CM_WORDS);
    localparam int CM_BYTE_W = $clog2(CM_DW / 8);
    localparam int CM_OFF_W  = CM_BEAT_W + CM_BYTE_W;
    localparam int CM_TAG_W  = CM_AW - CM_SET_W - CM_OFF_W;
    localparam int CM_LINE_W = CM_WORDS * CM_DW;
    // control field positions
    localparam int CM_CTL_EN    = 0;
    localparam int CM_CTL_PINV  = 1;
    localparam int CM_CTL_INVAL = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_BEAT,
        ST_SWEEP
    } cm_state_e;
endpackage

// File: rtl/cmc_dir.sv
module cmc_dir
    import cmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 tl_we,
    input  logic [CM_SET_W-1:0]  tl_set,
    input  logic [CM_WAY_W-1:0]  tl_way,
    input  logic                 tl_valid,
    input  logic                 tl_dirty,
    input  logic [CM_TAG_W-1:0]  tl_tag,
    input  logic [CM_LINE_W-1:0] tl_data,
    input  logic [CM_SET_W-1:0]  rd_set,
    input  logic [CM_WAY_W-1:0]  rd_way,
    output logic                 rd_valid,
    output logic                 rd_dirty,
    output logic [CM_TAG_W-1:0]  rd_tag,
    output logic [CM_LINE_W-1:0] rd_line,
    input  logic [CM_SET_W-1:0]  pr_set,
    input  logic [CM_WAY_W-1:0]  pr_way,
    output logic                 pr_valid,
    output logic                 pr_dirty,
    output logic [CM_TAG_W-1:0]  pr_tag,
    output logic [CM_LINE_W-1:0] pr_data,
    input  logic                 upd_en,
    input  logic [CM_SET_W-1:0]  upd_set,
    input  logic [CM_WAY_W-1:0]  upd_way,
    input  logic                 upd_inval,
    input  logic                 sweep_en,
    input  logic [CM_SET_W-1:0]  sweep_set
);
    // Arrays carry no reset: their contents survive a reset pulse.
    logic [CM_WAYS-1:0]  vld_q [CM_SETS];
    logic [CM_WAYS-1:0]  drt_q [CM_SETS];
    logic [CM_TAG_W-1:0] tag_q [CM_SETS][CM_WAYS];
    logic [CM_LINE_W-1:0] dat_q [CM_SETS][CM_WAYS];

    always_ff @(posedge clk) begin
        if (tl_we) begin
            vld_q[tl_set][tl_way] <= tl_valid;
            drt_q[tl_set][tl_way] <= tl_dirty;
        end
        if (sweep_en) begin
            vld_q[sweep_set] <= '0;
            drt_q[sweep_set] <= '0;
        end
        if (upd_en) begin
            drt_q[upd_set][upd_way] <= 1'b0;
            if (upd_inval) begin
                vld_q[upd_set][upd_way] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (tl_we) begin
            tag_q[tl_set][tl_way] <= tl_tag;
            dat_q[tl_set][tl_way] <= tl_data;
        end
    end

    always_comb begin
        rd_valid = vld_q[rd_set][rd_way];
        rd_dirty = drt_q[rd_set][rd_way];
        rd_tag   = tag_q[rd_set][rd_way];
        rd_line  = dat_q[rd_set][rd_way];
        pr_valid = vld_q[pr_set][pr_way];
        pr_dirty = drt_q[pr_set][pr_way];
        pr_tag   = tag_q[pr_set][pr_way];
        pr_data  = dat_q[pr_set][pr_way];
    end
endmodule

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
    import cmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [CM_AW-1:0]    ctl_wdata,
    input  logic                push_we,
    input  logic [CM_AW-1:0]    push_op,
    input  logic                take_push,
    input  logic                take_inv,
    output logic                cfg_en,
    output logic                cfg_pinv,
    output logic                pend_push,
    output logic                pend_inv,
    output logic [CM_SET_W-1:0] pend_set,
    output logic [CM_WAY_W-1:0] pend_way
);
    logic unused_fields;
    assign unused_fields = ^{ctl_wdata[CM_AW-1:CM_CTL_INVAL+1],
                             push_op[CM_AW-1:CM_OFF_W+CM_SET_W],
                             push_op[CM_OFF_W-1:CM_WAY_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en    <= 1'b0;
            cfg_pinv  <= 1'b0;
            pend_push <= 1'b0;
            pend_inv  <= 1'b0;
            pend_set  <= '0;
            pend_way  <= '0;
        end else begin
            if (take_push) pend_push <= 1'b0;
            if (take_inv)  pend_inv  <= 1'b0;
            if (ctl_we) begin
                cfg_en   <= ctl_wdata[CM_CTL_EN];
                cfg_pinv <= ctl_wdata[CM_CTL_PINV];
                if (ctl_wdata[CM_CTL_INVAL]) pend_inv <= 1'b1;
            end
            if (push_we) begin
                pend_push <= 1'b1;
                pend_set  <= push_op[CM_OFF_W +: CM_SET_W];
                pend_way  <= push_op[0 +: CM_WAY_W];
            end
        end
    end
endmodule

// File: rtl/cmc_fsm.sv
module cmc_fsm
    import cmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pend_push,
    input  logic                 pend_inv,
    input  logic [CM_SET_W-1:0]  pend_set,
    input  logic [CM_WAY_W-1:0]  pend_way,
    input  logic                 cfg_pinv,
    output logic                 take_push,
    output logic                 take_inv,
    output logic                 idle,
    output logic [CM_SET_W-1:0]  rd_set,
    output logic [CM_WAY_W-1:0]  rd_way,
    input  logic                 rd_valid,
    input  logic                 rd_dirty,
    input  logic [CM_TAG_W-1:0]  rd_tag,
    input  logic [CM_LINE_W-1:0] rd_line,
    output logic                 upd_en,
    output logic [CM_SET_W-1:0]  upd_set,
    output logic [CM_WAY_W-1:0]  upd_way,
    output logic                 upd_inval,
    output logic                 sweep_en,
    output logic [CM_SET_W-1:0]  sweep_set,
    output logic                 mw_valid,
    input  logic                 mw_ready,
    output logic [CM_AW-1:0]     mw_addr,
    output logic [CM_DW-1:0]     mw_data
);
    localparam logic [CM_BEAT_W-1:0] LAST_BEAT = CM_BEAT_W'(CM_WORDS - 1);
    localparam logic [CM_SET_W-1:0]  LAST_SET  = CM_SET_W'(CM_SETS - 1);

    cm_state_e            state_q, state_d;
    logic [CM_SET_W-1:0]  cur_set;
    logic [CM_WAY_W-1:0]  cur_way;
    logic                 cur_pol;
    logic [CM_TAG_W-1:0]  cur_tag;
    logic [CM_BEAT_W-1:0] beat_q;
    logic [CM_SET_W-1:0]  sweep_q;
    logic                 line_dirty;

    assign line_dirty = rd_valid && rd_dirty;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_push)     state_d = ST_LOOK;
                else if (pend_inv) state_d = ST_SWEEP;
            end
            ST_LOOK:  state_d = line_dirty ? ST_BEAT : ST_IDLE;
            ST_BEAT:  if (mw_ready && beat_q == LAST_BEAT) state_d = ST_IDLE;
            ST_SWEEP: if (sweep_q == LAST_SET) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_set <= '0;
            cur_way <= '0;
            cur_pol <= 1'b0;
            cur_tag <= '0;
            beat_q  <= '0;
            sweep_q <= '0;
        end else begin
            if (take_push) begin
                cur_set <= pend_set;
                cur_way <= pend_way;
                cur_pol <= cfg_pinv;
            end
            if (take_inv) sweep_q <= '0;
            if (state_q == ST_SWEEP) sweep_q <= sweep_q + 1'b1;
            if (state_q == ST_LOOK) begin
                cur_tag <= rd_tag;
                beat_q  <= '0;
            end
            if (state_q == ST_BEAT && mw_ready) beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        take_push = 1'b0;
        take_inv  = 1'b0;
        upd_en    = 1'b0;
        sweep_en  = 1'b0;
        mw_valid  = 1'b0;
        idle      = 1'b0;
        rd_set    = cur_set;
        rd_way    = cur_way;
        upd_set   = cur_set;
        upd_way   = cur_way;
        upd_inval = cur_pol;
        sweep_set = sweep_q;
        mw_addr   = {cur_tag, cur_set, beat_q, {CM_BYTE_W{1'b0}}};
        mw_data   = rd_line[beat_q*CM_DW +: CM_DW];
        unique case (state_q)
            ST_IDLE: begin
                idle      = 1'b1;
                take_push = pend_push;
                take_inv  = pend_inv && !pend_push;
            end
            ST_LOOK:  upd_en = !line_dirty;
            ST_BEAT: begin
                mw_valid = 1'b1;
                upd_en   = mw_ready && beat_q == LAST_BEAT;
            end
            ST_SWEEP: sweep_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cmc_top.sv
module cmc_top
    import cmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [CM_AW-1:0]     ctl_wdata,
    input  logic                 push_we,
    input  logic [CM_AW-1:0]     push_op,
    output logic                 busy,
    output logic                 cache_enable,
    output logic                 push_inval_mode,
    output logic                 mw_valid,
    input  logic                 mw_ready,
    output logic [CM_AW-1:0]     mw_addr,
    output logic [CM_DW-1:0]     mw_data,
    input  logic                 tl_we,
    input  logic [CM_SET_W-1:0]  tl_set,
    input  logic [CM_WAY_W-1:0]  tl_way,
    input  logic                 tl_valid,
    input  logic                 tl_dirty,
    input  logic [CM_TAG_W-1:0]  tl_tag,
    input  logic [CM_LINE_W-1:0] tl_data,
    input  logic [CM_SET_W-1:0]  pr_set,
    input  logic [CM_WAY_W-1:0]  pr_way,
    output logic                 pr_valid,
    output logic                 pr_dirty,
    output logic [CM_TAG_W-1:0]  pr_tag,
    output logic [CM_LINE_W-1:0] pr_data
);
    logic                 take_push, take_inv, fsm_idle;
    logic                 pend_push, pend_inv;
    logic [CM_SET_W-1:0]  pend_set, rd_set, upd_set, sweep_set;
    logic [CM_WAY_W-1:0]  pend_way, rd_way, upd_way;
    logic                 rd_valid, rd_dirty, upd_en, upd_inval, sweep_en;
    logic [CM_TAG_W-1:0]  rd_tag;
    logic [CM_LINE_W-1:0] rd_line;

    assign busy = !fsm_idle || pend_push || pend_inv;

    cmc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .push_we(push_we), .push_op(push_op),
        .take_push(take_push), .take_inv(take_inv),
        .cfg_en(cache_enable), .cfg_pinv(push_inval_mode),
        .pend_push(pend_push), .pend_inv(pend_inv),
        .pend_set(pend_set), .pend_way(pend_way)
    );

    cmc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pend_push(pend_push), .pend_inv(pend_inv),
        .pend_set(pend_set), .pend_way(pend_way),
        .cfg_pinv(push_inval_mode),
        .take_push(take_push), .take_inv(take_inv), .idle(fsm_idle),
        .rd_set(rd_set), .rd_way(rd_way),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_line(rd_line),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_inval(upd_inval),
        .sweep_en(sweep_en), .sweep_set(sweep_set),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
    );

    cmc_dir u_dir (
        .clk(clk),
        .tl_we(tl_we), .tl_set(tl_set), .tl_way(tl_way), .tl_valid(tl_valid),
        .tl_dirty(tl_dirty), .tl_tag(tl_tag), .tl_data(tl_data),
        .rd_set(rd_set), .rd_way(rd_way),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_line(rd_line),
        .pr_set(pr_set), .pr_way(pr_way),
        .pr_valid(pr_valid), .pr_dirty(pr_dirty), .pr_tag(pr_tag), .pr_data(pr_data),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_inval(upd_inval),
        .sweep_en(sweep_en), .sweep_set(sweep_set)
    );
endmodule

// File: rtl/cmc_chk.sv
module cmc_chk
    import cmc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [CM_AW-1:0] ctl_wdata,
    input logic             push_we,
    input logic             busy,
    input logic             cache_enable,
    input logic             push_inval_mode,
    input logic             mw_valid,
    input logic             mw_ready,
    input logic [CM_AW-1:0] mw_addr,
    input logic [CM_DW-1:0] mw_data
);
    localparam logic [CM_BEAT_W-1:0] LAST_BEAT = CM_BEAT_W'(CM_WORDS - 1);

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cache_enable && !push_inval_mode && !busy && !mw_valid);

    a_r3_ctl_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> cache_enable == $past(ctl_wdata[CM_CTL_EN])
                && push_inval_mode == $past(ctl_wdata[CM_CTL_PINV]));

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

    a_r7_word_align: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> mw_addr[CM_BYTE_W-1:0] == '0);

    a_r7_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && mw_ready && mw_addr[CM_BYTE_W +: CM_BEAT_W] != LAST_BEAT
        |=> mw_valid && mw_addr[CM_BYTE_W +: CM_BEAT_W]
            == $past(mw_addr[CM_BYTE_W +: CM_BEAT_W]) + 1'b1);

    a_r9_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        push_we || (ctl_we && ctl_wdata[CM_CTL_INVAL]) |=> busy);

    a_r9_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> busy);
endmodule

bind cmc_top cmc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .push_we(push_we), .busy(busy), .cache_enable(cache_enable),
    .push_inval_mode(push_inval_mode), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data)
);

// File: tb/cmc_top_tb.sv
`timescale 1ns/1ps
module cmc_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_we = 1'b0;
    logic [31:0]  ctl_wdata = '0;
    logic         push_we = 1'b0;
    logic [31:0]  push_op = '0;
    logic         busy, cache_enable, push_inval_mode, mw_valid;
    logic         mw_ready = 1'b1;
    logic [31:0]  mw_addr, mw_data;
    logic         tl_we = 1'b0;
    logic [8:0]   tl_set = '0;
    logic [1:0]   tl_way = '0;
    logic         tl_valid = 1'b0, tl_dirty = 1'b0;
    logic [18:0]  tl_tag = '0;
    logic [127:0] tl_data = '0;
    logic [8:0]   pr_set = '0;
    logic [1:0]   pr_way = '0;
    logic         pr_valid, pr_dirty;
    logic [18:0]  pr_tag;
    logic [127:0] pr_data;

    always #2.5 clk = ~clk;

    cmc_top u_dut (.*);

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [31:0] cap_a [16];
    logic [31:0] cap_d [16];

    typedef struct packed {
        logic [8:0]  set;
        logic [1:0]  way;
        logic [18:0] tag;
        logic        vld;
        logic        drt;
        logic        pol;
        logic        junk;
        logic        stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{9'd5,   2'd0, 19'h12345, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{9'd511, 2'd3, 19'h7FFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{9'd0,   2'd1, 19'h00001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{9'd200, 2'd2, 19'h0ABCD, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{9'd77,  2'd0, 19'h04444, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{9'd300, 2'd1, 19'h3C3C3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    function automatic logic [127:0] line_of(input logic [8:0] s, input logic [1:0] w);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) r[k*32 +: 32] = {7'h55, s, w, 12'hABC, 2'(k)};
        return r;
    endfunction

    function automatic logic [31:0] op_of(input logic [8:0] s, input logic [1:0] w, input logic junk);
        return {junk ? 19'h5A5A5 : 19'h0, s, junk ? 2'b11 : 2'b00, w};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [8:0] s, input logic [1:0] w, input logic v, input logic d,
                        input logic [18:0] t);
        tl_set = s; tl_way = w; tl_valid = v; tl_dirty = d; tl_tag = t;
        tl_data = line_of(s, w); tl_we = 1'b1;
        @(negedge clk); tl_we = 1'b0;
    endtask

    task automatic ctl_write(input logic [2:0] v);
        ctl_wdata = {29'h0, v}; ctl_we = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] op);
        push_op = op; push_we = 1'b1;
        @(negedge clk); push_we = 1'b0;
    endtask

    task automatic probe(input logic [8:0] s, input logic [1:0] w);
        pr_set = s; pr_way = w; #0.5;
    endtask

    task automatic drain(input bit stall, output int beats, output int cyc);
        beats = 0; cyc = 0;
        mw_ready = !stall;
        while (busy && cyc < 4000) begin
            cyc++;
            if (mw_valid && mw_ready) begin
                cap_a[beats % 16] = mw_addr;
                cap_d[beats % 16] = mw_data;
                beats++;
            end
            @(negedge clk);
            if (stall) mw_ready = ~mw_ready;
        end
        mw_ready = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int beats, cyc;
        logic [127:0] saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!cache_enable, "R1 enable", 128'(cache_enable), 0);
        chk(!push_inval_mode, "R1 policy", 128'(push_inval_mode), 0);
        chk(!busy && !mw_valid, "R1 busy/valid", 128'({busy, mw_valid}), 0);

        // R3: control fields follow the write
        ctl_write(3'b011);
        chk(cache_enable && push_inval_mode, "R3 fields set", 128'({cache_enable, push_inval_mode}), 128'b11);
        load(9'd9, 2'd1, 1'b1, 1'b1, 19'h0F0F0);
        ctl_write(3'b000);
        chk(!cache_enable && !push_inval_mode, "R3 fields clear", 128'({cache_enable, push_inval_mode}), 0);
        probe(9'd9, 2'd1);
        chk(pr_valid && pr_dirty && pr_tag == 19'h0F0F0, "R3 enable leaves contents",
            128'({pr_valid, pr_dirty, pr_tag}), 128'({2'b11, 19'h0F0F0}));

        // table of push vectors: R5 R6 R7 R8, enable alternates (R3)
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            int exp_beats;
            v = VECS[i];
            exp_beats = (v.vld && v.drt) ? 4 : 0;
            ctl_write({1'b0, v.pol, 1'(i % 2)});
            load(v.set, v.way, v.vld, v.drt, v.tag);
            push(op_of(v.set, v.way, v.junk));
            drain(v.stall, beats, cyc);
            chk(beats == exp_beats, exp_beats == 4 ? "R7 beat count" : "R6 no write",
                128'(beats), 128'(exp_beats));
            if (exp_beats == 4) begin
                for (int w = 0; w < 4; w++) begin
                    logic [31:0] ea;
                    ea = {v.tag, v.set, 2'(w), 2'b00};
                    chk(cap_a[w] == ea, "R7 R5 beat address", 128'(cap_a[w]), 128'(ea));
                    chk(cap_d[w] == line_of(v.set, v.way)[w*32 +: 32], "R7 beat data",
                        128'(cap_d[w]), 128'(line_of(v.set, v.way)[w*32 +: 32]));
                end
                if (!v.stall) chk(cyc == 6, "R8 busy length", 128'(cyc), 6);
            end else begin
                chk(cyc == 2, "R6 busy length", 128'(cyc), 2);
            end
            probe(v.set, v.way);
            chk(pr_valid == (v.vld && !v.pol), exp_beats == 4 ? "R8 final valid" : "R6 final valid",
                128'(pr_valid), 128'(v.vld && !v.pol));
            chk(!pr_dirty, "R8 R6 line clean", 128'(pr_dirty), 0);
            chk(pr_tag == v.tag && pr_data == line_of(v.set, v.way), "R5 R7 other state kept",
                pr_data, line_of(v.set, v.way));
        end

        // R2: reset keeps the arrays
        load(9'd10, 2'd2, 1'b1, 1'b1, 19'h2468A);
        ctl_write(3'b011);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cache_enable && !push_inval_mode, "R1 control cleared again",
            128'({cache_enable, push_inval_mode}), 0);
        probe(9'd10, 2'd2);
        chk(pr_valid && pr_dirty && pr_tag == 19'h2468A, "R2 state kept",
            128'({pr_valid, pr_dirty, pr_tag}), 128'({2'b11, 19'h2468A}));
        chk(pr_data == line_of(9'd10, 2'd2), "R2 data kept", pr_data, line_of(9'd10, 2'd2));

        // R4: invalidate-all with enable clear
        load(9'd0, 2'd0, 1'b1, 1'b0, 19'h1);
        load(9'd511, 2'd3, 1'b1, 1'b1, 19'h2);
        load(9'd256, 2'd1, 1'b1, 1'b1, 19'h3);
        saved = line_of(9'd256, 2'd1);
        ctl_write(3'b100);
        drain(1'b0, beats, cyc);
        chk(cyc == 513, "R4 sweep length", 128'(cyc), 513);
        chk(beats == 0, "R4 no write", 128'(beats), 0);
        probe(9'd0, 2'd0);
        chk(!pr_valid, "R4 set0 way0 cleared", 128'(pr_valid), 0);
        probe(9'd511, 2'd3);
        chk(!pr_valid && !pr_dirty, "R4 last set cleared", 128'({pr_valid, pr_dirty}), 0);
        probe(9'd256, 2'd1);
        chk(!pr_valid && pr_data == saved, "R4 mid set cleared, data kept",
            128'(pr_valid), 0);

        // R9: second push while busy is held and run afterwards
        ctl_write(3'b001);
        load(9'd3, 2'd0, 1'b1, 1'b1, 19'h11111);
        load(9'd4, 2'd1, 1'b1, 1'b1, 19'h22222);
        push(op_of(9'd3, 2'd0, 1'b0));
        chk(busy, "R9 busy after write", 128'(busy), 1);
        push(op_of(9'd4, 2'd1, 1'b0));
        drain(1'b0, beats, cyc);
        chk(beats == 8, "R9 both pushes written", 128'(beats), 8);
        chk(cap_a[4] == {19'h22222, 9'd4, 4'h0}, "R9 held push address",
            128'(cap_a[4]), 128'({19'h22222, 9'd4, 4'h0}));
        probe(9'd4, 2'd1);
        chk(pr_valid && !pr_dirty, "R9 held push applied", 128'({pr_valid, pr_dirty}), 128'b10);

        // R10: push and invalidate-all in the same cycle
        load(9'd33, 2'd2, 1'b1, 1'b1, 19'h55555);
        push_op = op_of(9'd33, 2'd2, 1'b0); push_we = 1'b1;
        ctl_wdata = 32'h6; ctl_we = 1'b1;
        @(negedge clk);
        push_we = 1'b0; ctl_we = 1'b0;
        drain(1'b0, beats, cyc);
        chk(beats == 4, "R10 push served first", 128'(beats), 4);
        chk(cap_a[0] == {19'h55555, 9'd33, 4'h0}, "R10 first beat address",
            128'(cap_a[0]), 128'({19'h55555, 9'd33, 4'h0}));
        probe(9'd33, 2'd2);
        chk(!pr_valid, "R10 swept afterwards", 128'(pr_valid), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule